// File: doc/BRIEF.md
# Waveform Sample Buffer with Data Request and Cyclic Replay

This block buffers 16-bit output samples between a host or DMA writer and the sequencer that updates a converter. The writer pushes samples through a write port. The sequencer pops one sample per update pulse while its timing signal is running. A request output tells the writer when to send more data. A mode input chooses between two request rules: request whenever there is room, or request only while the buffer is less than half occupied. In the second rule the writer can send half the capacity in one burst without checking the flags.

The block also has a cyclic mode for waveforms that fit entirely in the buffer. On entering this mode, the block records the span of stored samples. Pops then walk that span and wrap back to its first sample, and nothing is consumed. An optional stop setting ends the replay after the last sample of the span, so the sample left on the output is a known final value. When cyclic mode is left, normal consuming pops resume from the oldest stored sample.

Top module: `wave_sample_buffer`

## Requirements
- R1: After reset, or in the cycle after `clr` is high, `empty`=1, `full`=0, `half`=0, `overflow`=0, `cyc_done`=0 and `req`=1, and the buffer holds no samples.
- R2: In normal mode (`cyc_en`=0), a pop with `run`=1 on a non-empty buffer removes the oldest sample. That sample appears on `rd_data` with `rd_valid`=1 in the cycle after the pop.
- R3: A pop is ignored when `run`=0 or the buffer is empty. No `rd_valid` follows and the occupancy is unchanged.
- R4: The flags are registered and change in the cycle after the write or pop that changes the occupancy. `empty` means 0 samples, `full` means DEPTH samples, and `half` means at least DEPTH/2 samples.
- R5: A write while `full`=1 is dropped and sets `overflow`. `overflow` stays set until `clr` or reset.
- R6: With `req_mode`=0, `req` is high whenever the buffer is not full. With `req_mode`=1, `req` is high only while it holds fewer than DEPTH/2 samples. `req` follows a mode change one cycle later.
- R7: In cyclic mode, pops return the stored samples from oldest to newest and then wrap to the oldest again. Nothing is consumed, so after `cyc_en` falls, normal pops return every stored sample in order.
- R8: With `cyc_stop`=1 when the newest sample of the span is popped, `cyc_done` rises in the next cycle. Later pops produce no `rd_valid`, and `rd_data` keeps that last sample. `cyc_done` clears when `cyc_en` falls.
- R9: The replay span is fixed in the cycle where `cyc_en` rises. Pops in that cycle are ignored. Samples written afterwards are not replayed.
- R10: `clr` empties the buffer, clears `overflow` and `cyc_done`, and re-arms the replay if `cyc_en` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear of pointers, flags and stop state |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Sample to store |
| pop | input | 1 | Read strobe from the update sequencer |
| run | input | 1 | Timing signal active; pops count only while high |
| req_mode | input | 1 | 0: request when not full; 1: request when below half |
| cyc_en | input | 1 | Cyclic replay mode |
| cyc_stop | input | 1 | Stop replay at the end of the span |
| rd_data | output | 16 | Last popped sample |
| rd_valid | output | 1 | `rd_data` was updated in this cycle |
| full | output | 1 | Buffer full |
| empty | output | 1 | Buffer empty |
| half | output | 1 | At least half occupied |
| overflow | output | 1 | Sticky dropped-write flag |
| req | output | 1 | Data request to the writer |
| cyc_done | output | 1 | Cyclic replay stopped at end of span |

## Verification
On every cycle, the checker verifies that the flags are mutually consistent and that `req` matches `full` under the not-full rule. It also checks that `overflow` and `cyc_done` are sticky, that ignored pops produce no output, and that cyclic pops leave the occupancy flags alone. Only the bench scenarios can show the data itself. That includes first-in first-out order across a full buffer, the wrap point of the replay, the exclusion of samples written after arming, and the final held sample after a stop.

// File: rtl/wsb_pkg.sv
// Shared types for the waveform sample buffer.
// Assumes nothing beyond IEEE 1800-2017.
package wsb_pkg;

    // Request rule selected by the req_mode input.
    typedef enum logic {
        REQ_NOT_FULL   = 1'b0,
        REQ_BELOW_HALF = 1'b1
    } req_mode_e;

endpackage

// File: rtl/wsb_store.sv
// Sample storage: one synchronous write port and one registered read port.
// Assumes the controller never reads and writes the same entry in one cycle.
module wsb_store #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 2048,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Store an incoming sample.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Register the popped sample and hold it until the next pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= mem[raddr];
        end
    end

    // Flag the cycle in which rdata carries a new sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
        end else begin
            rvalid <= re;
        end
    end

endmodule

// File: rtl/wsb_ctrl.sv
// Pointer and mode control: write/read pointers, occupancy, overflow,
// and the cyclic replay pointer with its span markers and stop state.
// Assumes DEPTH is a power of two, so pointers wrap by natural overflow.
module wsb_ctrl #(
    parameter int DEPTH  = 2048,
    parameter int ADDR_W = $clog2(DEPTH),
    parameter int CNT_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic              pop,
    input  logic              run,
    input  logic              cyc_en,
    input  logic              cyc_stop,
    output logic              we,
    output logic [ADDR_W-1:0] waddr,
    output logic              re,
    output logic [ADDR_W-1:0] raddr,
    output logic [CNT_W-1:0]  count_nxt,
    output logic              overflow,
    output logic              cyc_done
);

    localparam logic [CNT_W-1:0] CAP = CNT_W'(DEPTH);

    logic [ADDR_W-1:0] wr_ptr;
    logic [ADDR_W-1:0] rd_ptr;
    logic [ADDR_W-1:0] rp;
    logic [ADDR_W-1:0] rp_inc;
    logic [ADDR_W-1:0] span_end;
    logic [CNT_W-1:0]  count;
    logic              cyc_en_q;
    logic              span_zero;
    logic              cnt_full;
    logic              cnt_empty;
    logic              cyc_arm;
    logic              cyc_live;
    logic              wr_go;
    logic              pop_norm;
    logic              pop_cyc;
    logic              at_last;

    // Decode the accepted operations for this cycle.
    always_comb begin
        cnt_full  = (count == CAP);
        cnt_empty = (count == '0);
        cyc_arm   = cyc_en && !cyc_en_q;
        cyc_live  = cyc_en && cyc_en_q;
        wr_go     = wr_en && !cnt_full && !clr;
        pop_norm  = pop && run && !cyc_en && !cnt_empty && !clr;
        pop_cyc   = pop && run && cyc_live && !span_zero && !cyc_done && !clr;
        rp_inc    = rp + 1'b1;
        at_last   = (rp_inc == span_end);
    end

    // Drive the storage ports.
    always_comb begin
        we    = wr_go;
        waddr = wr_ptr;
        re    = pop_norm || pop_cyc;
        raddr = cyc_live ? rp : rd_ptr;
    end

    // Next occupancy, also used by the flag register stage.
    always_comb begin
        if (clr) begin
            count_nxt = '0;
        end else begin
            count_nxt = count + CNT_W'(wr_go) - CNT_W'(pop_norm);
        end
    end

    // Advance the write pointer on every accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
        end else if (wr_go) begin
            wr_ptr <= wr_ptr + 1'b1;
        end
    end

    // Advance the read pointer only on consuming pops.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            rd_ptr <= '0;
        end else if (pop_norm) begin
            rd_ptr <= rd_ptr + 1'b1;
        end
    end

    // Track the occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            count <= count_nxt;
        end
    end

    // Remember the previous cyclic mode to detect arming; clr forces a re-arm.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cyc_en_q <= 1'b0;
        end else begin
            cyc_en_q <= cyc_en;
        end
    end

    // Capture the replay span when armed and step the replay pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rp        <= '0;
            span_end  <= '0;
            span_zero <= 1'b1;
        end else if (cyc_arm && !clr) begin
            rp        <= rd_ptr;
            span_end  <= wr_ptr;
            span_zero <= cnt_empty;
        end else if (pop_cyc) begin
            rp <= at_last ? rd_ptr : rp_inc;
        end
    end

    // Latch the stop state after the last sample of the span.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || !cyc_en) begin
            cyc_done <= 1'b0;
        end else if (pop_cyc && at_last && cyc_stop) begin
            cyc_done <= 1'b1;
        end
    end

    // Record any write dropped for lack of room.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            overflow <= 1'b0;
        end else if (wr_en && cnt_full) begin
            overflow <= 1'b1;
        end
    end

endmodule

// File: rtl/wsb_flags.sv
// Registered status flags and data request, computed from the next occupancy
// so they change in the same cycle as the occupancy itself.
// Assumes count_nxt never exceeds DEPTH.
module wsb_flags
    import wsb_pkg::*;
#(
    parameter int DEPTH = 2048,
    parameter int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count_nxt,
    input  req_mode_e        mode,
    output logic             full,
    output logic             empty,
    output logic             half,
    output logic             req
);

    localparam logic [CNT_W-1:0] CAP  = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] HALF = CNT_W'(DEPTH / 2);

    // Register the occupancy flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full  <= 1'b0;
            empty <= 1'b1;
            half  <= 1'b0;
        end else begin
            full  <= (count_nxt == CAP);
            empty <= (count_nxt == '0);
            half  <= (count_nxt >= HALF);
        end
    end

    // Register the request under the selected rule.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req <= 1'b1;
        end else if (mode == REQ_BELOW_HALF) begin
            req <= (count_nxt < HALF);
        end else begin
            req <= (count_nxt != CAP);
        end
    end

endmodule

// File: rtl/wave_sample_buffer.sv
// Top level of the waveform sample buffer: storage, pointer control and flags.
// Assumes DEPTH is a power of two and at least 4.
module wave_sample_buffer
    import wsb_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 2048
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              pop,
    input  logic              run,
    input  logic              req_mode,
    input  logic              cyc_en,
    input  logic              cyc_stop,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              full,
    output logic              empty,
    output logic              half,
    output logic              overflow,
    output logic              req,
    output logic              cyc_done
);

    localparam int ADDR_W = $clog2(DEPTH);
    localparam int CNT_W  = ADDR_W + 1;

    logic              we;
    logic              re;
    logic [ADDR_W-1:0] waddr;
    logic [ADDR_W-1:0] raddr;
    logic [CNT_W-1:0]  count_nxt;
    req_mode_e         mode;

    // Map the plain mode pin onto the request rule type.
    always_comb begin
        mode = req_mode_e'(req_mode);
    end

    wsb_ctrl #(
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .wr_en     (wr_en),
        .pop       (pop),
        .run       (run),
        .cyc_en    (cyc_en),
        .cyc_stop  (cyc_stop),
        .we        (we),
        .waddr     (waddr),
        .re        (re),
        .raddr     (raddr),
        .count_nxt (count_nxt),
        .overflow  (overflow),
        .cyc_done  (cyc_done)
    );

    wsb_store #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W)
    ) i_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (we),
        .waddr  (waddr),
        .wdata  (wr_data),
        .re     (re),
        .raddr  (raddr),
        .rdata  (rd_data),
        .rvalid (rd_valid)
    );

    wsb_flags #(
        .DEPTH (DEPTH),
        .CNT_W (CNT_W)
    ) i_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .count_nxt (count_nxt),
        .mode      (mode),
        .full      (full),
        .empty     (empty),
        .half      (half),
        .req       (req)
    );

endmodule

// File: rtl/wsb_checker.sv
// Cycle-by-cycle properties of the waveform sample buffer, bound to the top.
// Observes top-level ports only.
module wsb_checker (
    input logic clk,
    input logic rst_n,
    input logic clr,
    input logic wr_en,
    input logic pop,
    input logic run,
    input logic req_mode,
    input logic cyc_en,
    input logic rd_valid,
    input logic full,
    input logic empty,
    input logic half,
    input logic overflow,
    input logic req,
    input logic cyc_done
);

    AST_FULL_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty)) else $error("full and empty together"); // R4

    AST_FULL_IMPLIES_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> half) else $error("full without half"); // R4

    AST_REQ_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(req_mode) == 1'b0) |-> (req == !full)) else $error("req rule 0"); // R6

    AST_IDLE_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (!run || (empty && !cyc_en)) |=> !rd_valid) else $error("ignored pop produced data"); // R3

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !clr) |=> overflow) else $error("overflow lost"); // R5

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_done && cyc_en && !clr) |=> (cyc_done && !rd_valid)) else $error("replay resumed"); // R8

    AST_CYC_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_en && !wr_en && !clr) |=> ($stable(empty) && $stable(half) && $stable(full)))
        else $error("cyclic pop consumed"); // R7

    AST_CLR_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (empty && !full && !overflow && !cyc_done)) else $error("clear incomplete"); // R10

endmodule

bind wave_sample_buffer wsb_checker i_wsb_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .wr_en    (wr_en),
    .pop      (pop),
    .run      (run),
    .req_mode (req_mode),
    .cyc_en   (cyc_en),
    .rd_valid (rd_valid),
    .full     (full),
    .empty    (empty),
    .half     (half),
    .overflow (overflow),
    .req      (req),
    .cyc_done (cyc_done)
);

// File: tb/test_wave_sample_buffer.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected samples, a monitor compares.
module test_wave_sample_buffer;

    localparam int DW    = 16;
    localparam int DEPTH = 16;
    localparam int HALF  = DEPTH / 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clr = 1'b0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          pop = 1'b0;
    logic          run = 1'b0;
    logic          req_mode = 1'b0;
    logic          cyc_en = 1'b0;
    logic          cyc_stop = 1'b0;
    logic [DW-1:0] rd_data;
    logic          rd_valid;
    logic          full, empty, half, overflow, req, cyc_done;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] mdl[$];
    logic [DW-1:0] exp_q[$];
    string         tag_q[$];

    always #2.5 clk = ~clk;

    wave_sample_buffer #(.DATA_W(DW), .DEPTH(DEPTH)) i_wave_sample_buffer (
        .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_en), .wr_data(wr_data),
        .pop(pop), .run(run), .req_mode(req_mode), .cyc_en(cyc_en),
        .cyc_stop(cyc_stop), .rd_data(rd_data), .rd_valid(rd_valid),
        .full(full), .empty(empty), .half(half), .overflow(overflow),
        .req(req), .cyc_done(cyc_done)
    );

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic push_word(input logic [DW-1:0] d);
        wr_en = 1'b1; wr_data = d;
        if (mdl.size() < DEPTH) mdl.push_back(d);
        tick();
        wr_en = 1'b0;
    endtask

    // Consuming pop following the model.
    task automatic pop_norm(input string rq);
        pop = 1'b1;
        if (run && mdl.size() > 0) begin
            exp_q.push_back(mdl.pop_front());
            tag_q.push_back(rq);
        end
        tick();
        pop = 1'b0;
    endtask

    // Pop with an explicitly stated outcome (cyclic scenarios).
    task automatic pop_exp(input bit acc, input logic [DW-1:0] d, input string rq);
        pop = 1'b1;
        if (acc) begin
            exp_q.push_back(d);
            tag_q.push_back(rq);
        end
        tick();
        pop = 1'b0;
    endtask

    // Monitor: compare every produced sample against the queue.
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3 unexpected rd_valid", int'(rd_data), 0);
            end else begin
                automatic logic [DW-1:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(rd_data == e, t, int'(rd_data), int'(e));
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        check(empty && !full && !half && !overflow && !cyc_done && req && !rd_valid,
              "R1 reset flags", {full, empty, half, overflow, req, cyc_done}, 6'b010010);

        // R6 below-half rule and R4 half boundary
        req_mode = 1'b1;
        for (int i = 0; i < HALF - 1; i++) push_word(16'h1000 + 16'(i));
        check(req && !half, "R6 req below half", {req, half}, 2'b10);
        push_word(16'h1000 + 16'(HALF - 1));
        check(!req && half && !empty, "R4 R6 half reached", {req, half, empty}, 3'b010);

        // R3 pops without run are ignored
        run = 1'b0;
        repeat (3) pop_norm("R3");
        tick();
        check(half, "R3 occupancy kept", half, 1);

        // R2 ordered consuming pops
        run = 1'b1;
        repeat (3) pop_norm("R2 order");
        tick();
        check(!half && req, "R2 R6 after pops", {half, req}, 2'b01);

        // Fill to full, R4/R5/R6 rule 0
        req_mode = 1'b0;
        while (mdl.size() < DEPTH) push_word(16'h2000 + 16'(mdl.size()));
        check(full && !req, "R4 R6 full", {full, req}, 2'b10);
        push_word(16'hDEAD);
        check(overflow && full, "R5 overflow set", {overflow, full}, 2'b11);

        // Drain; dropped word must not appear
        while (mdl.size() > 0) pop_norm("R2 R5 drain");
        tick();
        check(empty && !full && req, "R4 empty after drain", {empty, full, req}, 3'b101);
        check(overflow, "R5 sticky", overflow, 1);
        pop_norm("R3 empty pop");
        tick();

        // R10 / R1 clear
        clr = 1'b1; tick(); clr = 1'b0;
        check(!overflow && empty && req, "R10 clear", {overflow, empty, req}, 3'b011);

        // R7 R9 cyclic replay
        for (int i = 0; i < 5; i++) push_word(16'hA000 + 16'(i));
        cyc_en = 1'b1;
        pop_exp(1'b0, '0, "R9 arm pop ignored");
        tick();
        push_word(16'hA005);
        for (int i = 0; i < 12; i++) pop_exp(1'b1, 16'hA000 + 16'(i % 5), "R7 R9 replay");
        tick();
        cyc_en = 1'b0;
        tick();
        check(!empty, "R7 not consumed", empty, 0);
        while (mdl.size() > 0) pop_norm("R7 after replay");
        tick();
        check(empty, "R7 drained", empty, 1);

        // R8 stop at end of span
        for (int i = 0; i < 3; i++) push_word(16'hB000 + 16'(i));
        cyc_stop = 1'b1;
        cyc_en = 1'b1;
        tick(); tick();
        for (int i = 0; i < 3; i++) pop_exp(1'b1, 16'hB000 + 16'(i), "R8 replay");
        repeat (3) pop_exp(1'b0, '0, "R8 after stop");
        tick();
        check(cyc_done, "R8 done", cyc_done, 1);
        check(rd_data == 16'hB002, "R8 final sample", int'(rd_data), 16'hB002);

        // R10 clear ends stop state
        clr = 1'b1; tick(); clr = 1'b0;
        mdl.delete();
        check(!cyc_done && empty, "R10 clear stop", {cyc_done, empty}, 2'b01);
        cyc_en = 1'b0; cyc_stop = 1'b0;
        repeat (3) tick();
        check(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule